// File: doc/BRIEF.md
# Program Counter with Return-Address Stack

This block holds the 10-bit instruction address for a 1K-word program store and keeps an 8-entry ring of return addresses. Each cycle the decoder hands it a set of control strobes (advance, skip, long jump, long call, three return variants, a data write to the low address byte, and interrupt entry). The block selects the next address, pushes or pops the ring, and reports the new address to the fetch stage.

For the long jump and long call strobes, the full 10-bit address comes from the instruction's address field. When the low address byte is written as ordinary data, only bits 7:0 come from the ALU result. The upper two bits then come from a separate high-byte latch input. Any strobe that breaks sequential flow raises a flush indication one cycle later, so that the fetch stage can discard the prefetched word. With no strobe asserted, the address holds. This is the sleep state, and waking resumes with an advance to the following word.

Top module: `prog_counter`

## Requirements
- R1: While rst_ni is low and after its release, fetch_addr_o is 000h, pcl_o is 00h, flush_o is 0 and the return ring is empty (write slot 0).
- R2: An advance strobe alone loads PC+1 modulo 1024. From 3FFh it goes to 000h.
- R3: A skip strobe loads PC+2 modulo 1024. This applies with or without the advance strobe.
- R4: A long jump loads target_i into the PC.
- R5: A long call writes PC+1 modulo 1024 into the ring slot at the write index, advances the index by one, and loads target_i.
- R6: Any of the three return strobes (ret_i, retw_i, reti_i) steps the index back by one and loads the PC from the slot it then points to.
- R7: A write to the low byte loads the PC as {hi_latch_i[1:0], alu_i[7:0]}, and pcl_o always shows PC bits 7:0.
- R8: Interrupt entry pushes the current PC (the instruction it displaces) and loads 004h.
- R9: When several strobes are high, only one takes effect, in this priority from highest to lowest: interrupt, call, jump, return, low-byte write, skip, advance. With none high, the PC holds.
- R10: The ring has 8 slots with a 3-bit index that wraps modulo 8. A ninth push overwrites slot 0, and a pop past empty reads around the ring. No overflow indication exists.
- R11: flush_o is 1 in the cycle after an interrupt, call, jump, return or low-byte write, and 0 in the cycle after anything else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| adv_i | input | 1 | Sequential advance |
| skip_i | input | 1 | Skip next word |
| jump_i | input | 1 | Long jump |
| call_i | input | 1 | Long call |
| ret_i | input | 1 | Plain return |
| retw_i | input | 1 | Return with immediate to W |
| reti_i | input | 1 | Return from interrupt |
| pcl_wr_i | input | 1 | Data write to low PC byte |
| int_i | input | 1 | Interrupt entry |
| target_i | input | 10 | Instruction address field |
| alu_i | input | 8 | ALU result |
| hi_latch_i | input | 2 | High-byte latch register bits |
| fetch_addr_o | output | 10 | Current fetch address |
| pcl_o | output | 8 | Readable low PC byte |
| flush_o | output | 1 | Discard prefetched word |

## Verification
Interrupt entry and a long call can both push in the same cycle, and a return can coincide with a pending push. These collisions are provoked in a directed case that raises int_i together with call_i and ret_i. The random phase also raises several strobes at once. The result is judged by checking that the address is 004h, that the ring gains exactly the displaced PC, and that a later return gives that PC back. A second directed case makes nine nested calls followed by nine returns to show the ring wrapping.

// File: rtl/prog_counter_pkg.sv
package prog_counter_pkg;
  typedef enum logic [2:0] {
    SEL_HOLD = 3'd0,
    SEL_INC  = 3'd1,
    SEL_SKIP = 3'd2,
    SEL_JUMP = 3'd3,
    SEL_CALL = 3'd4,
    SEL_RET  = 3'd5,
    SEL_PCL  = 3'd6,
    SEL_INT  = 3'd7
  } pc_sel_e;
endpackage

// File: rtl/pc_sel_dec.sv
module pc_sel_dec
  import prog_counter_pkg::*;
(
  input  logic    adv_i,
  input  logic    skip_i,
  input  logic    jump_i,
  input  logic    call_i,
  input  logic    ret_any_i,
  input  logic    pcl_wr_i,
  input  logic    int_i,
  output pc_sel_e sel_o
);
  always_comb begin
    if (int_i)          sel_o = SEL_INT;
    else if (call_i)    sel_o = SEL_CALL;
    else if (jump_i)    sel_o = SEL_JUMP;
    else if (ret_any_i) sel_o = SEL_RET;
    else if (pcl_wr_i)  sel_o = SEL_PCL;
    else if (skip_i)    sel_o = SEL_SKIP;
    else if (adv_i)     sel_o = SEL_INC;
    else                sel_o = SEL_HOLD;
  end
endmodule

// File: rtl/pc_next_mux.sv
module pc_next_mux
  import prog_counter_pkg::*;
#(
  parameter int unsigned PC_W    = 10,
  parameter int unsigned LO_W    = 8,
  parameter logic [PC_W-1:0] INT_VEC = 'h004,
  localparam int unsigned HI_W   = PC_W - LO_W
) (
  input  pc_sel_e          sel_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  target_i,
  input  logic [LO_W-1:0]  alu_i,
  input  logic [HI_W-1:0]  hi_latch_i,
  input  logic [PC_W-1:0]  pop_val_i,
  output logic [PC_W-1:0]  pc_nxt_o,
  output logic             push_o,
  output logic             pop_o,
  output logic [PC_W-1:0]  push_val_o,
  output logic             flow_o
);
  logic [PC_W-1:0] pc_inc;
  assign pc_inc = pc_i + PC_W'(1);

  always_comb begin
    pc_nxt_o   = pc_i;
    push_o     = 1'b0;
    pop_o      = 1'b0;
    push_val_o = pc_inc;
    flow_o     = 1'b0;
    unique case (sel_i)
      SEL_INC:  pc_nxt_o = pc_inc;
      SEL_SKIP: pc_nxt_o = pc_i + PC_W'(2);
      SEL_JUMP: begin pc_nxt_o = target_i; flow_o = 1'b1; end
      SEL_CALL: begin pc_nxt_o = target_i; push_o = 1'b1; flow_o = 1'b1; end
      SEL_RET:  begin pc_nxt_o = pop_val_i; pop_o = 1'b1; flow_o = 1'b1; end
      SEL_PCL:  begin pc_nxt_o = {hi_latch_i, alu_i}; flow_o = 1'b1; end
      SEL_INT:  begin
        pc_nxt_o   = INT_VEC;
        push_o     = 1'b1;
        push_val_o = pc_i;
        flow_o     = 1'b1;
      end
      default:  pc_nxt_o = pc_i;
    endcase
  end
endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] push_val_i,
  output logic [DATA_W-1:0] top_o
);
  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [IDX_W-1:0]  wr_idx_q;
  logic [IDX_W-1:0]  rd_idx;

  // index wraps modulo DEPTH (power of two)
  assign rd_idx = wr_idx_q - IDX_W'(1);
  assign top_o  = slot_q[rd_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_idx_q <= '0;
    end else if (push_i) begin
      wr_idx_q <= wr_idx_q + IDX_W'(1);
    end else if (pop_i) begin
      wr_idx_q <= rd_idx;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[g] <= '0;
      else if (push_i && (wr_idx_q == IDX_W'(g))) slot_q[g] <= push_val_i;
    end
  end
endmodule

// File: rtl/prog_counter.sv
module prog_counter
  import prog_counter_pkg::*;
#(
  parameter int unsigned PC_W    = 10,
  parameter int unsigned LO_W    = 8,
  parameter int unsigned DEPTH   = 8,
  parameter logic [PC_W-1:0] INT_VEC = 'h004,
  localparam int unsigned HI_W   = PC_W - LO_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  input  logic            skip_i,
  input  logic            jump_i,
  input  logic            call_i,
  input  logic            ret_i,
  input  logic            retw_i,
  input  logic            reti_i,
  input  logic            pcl_wr_i,
  input  logic            int_i,
  input  logic [PC_W-1:0] target_i,
  input  logic [LO_W-1:0] alu_i,
  input  logic [HI_W-1:0] hi_latch_i,
  output logic [PC_W-1:0] fetch_addr_o,
  output logic [LO_W-1:0] pcl_o,
  output logic            flush_o
);
  pc_sel_e         sel;
  logic [PC_W-1:0] pc_q, pc_nxt, push_val, pop_val;
  logic            push, pop, flow, ret_any;

  assign ret_any = ret_i | retw_i | reti_i;

  pc_sel_dec u_dec (
    .adv_i, .skip_i, .jump_i, .call_i,
    .ret_any_i (ret_any),
    .pcl_wr_i, .int_i,
    .sel_o     (sel)
  );

  pc_next_mux #(.PC_W(PC_W), .LO_W(LO_W), .INT_VEC(INT_VEC)) u_mux (
    .sel_i      (sel),
    .pc_i       (pc_q),
    .target_i,
    .alu_i,
    .hi_latch_i,
    .pop_val_i  (pop_val),
    .pc_nxt_o   (pc_nxt),
    .push_o     (push),
    .pop_o      (pop),
    .push_val_o (push_val),
    .flow_o     (flow)
  );

  pc_ret_stack #(.DATA_W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk_i, .rst_ni,
    .push_i     (push),
    .pop_i      (pop),
    .push_val_i (push_val),
    .top_o      (pop_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      flush_o <= 1'b0;
    end else begin
      pc_q    <= pc_nxt;
      flush_o <= flow;
    end
  end

  assign fetch_addr_o = pc_q;
  assign pcl_o        = pc_q[LO_W-1:0];
endmodule

// File: rtl/prog_counter_chk.sv
module prog_counter_chk #(
  parameter int unsigned PC_W = 10,
  parameter int unsigned LO_W = 8,
  localparam int unsigned HI_W = PC_W - LO_W
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            adv_i,
  input logic            skip_i,
  input logic            jump_i,
  input logic            call_i,
  input logic            ret_i,
  input logic            retw_i,
  input logic            reti_i,
  input logic            pcl_wr_i,
  input logic            int_i,
  input logic [PC_W-1:0] target_i,
  input logic [LO_W-1:0] alu_i,
  input logic [HI_W-1:0] hi_latch_i,
  input logic [PC_W-1:0] fetch_addr_o,
  input logic [LO_W-1:0] pcl_o,
  input logic            flush_o
);
  logic ret_any, flow_req;
  assign ret_any  = ret_i | retw_i | reti_i;
  assign flow_req = int_i | call_i | jump_i | ret_any | pcl_wr_i;

  a_r8_int_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_i |=> fetch_addr_o == PC_W'('h004));

  a_r4_jump_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_i && !int_i && !call_i) |=> fetch_addr_o == $past(target_i));

  a_r7_pcl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcl_wr_i && !int_i && !call_i && !jump_i && !ret_any)
      |=> fetch_addr_o == {$past(hi_latch_i), $past(alu_i)});

  a_r2_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !skip_i && !flow_req) |=> fetch_addr_o == $past(fetch_addr_o) + PC_W'(1));

  a_r3_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skip_i && !flow_req) |=> fetch_addr_o == $past(fetch_addr_o) + PC_W'(2));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !skip_i && !flow_req) |=> $stable(fetch_addr_o));

  a_r11_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flow_req |=> flush_o);

  a_r11_no_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flow_req |=> !flush_o);

  a_r5_call_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !int_i) ##1 (ret_any && !int_i && !call_i && !jump_i)
      |=> fetch_addr_o == $past(fetch_addr_o, 2) + PC_W'(1));

  a_r7_pcl_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcl_o == fetch_addr_o[LO_W-1:0]);
endmodule

bind prog_counter prog_counter_chk #(.PC_W(PC_W), .LO_W(LO_W)) u_chk (.*);

// File: tb/prog_counter_tb_top.sv
module prog_counter_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       adv_i = 0, skip_i = 0, jump_i = 0, call_i = 0;
  logic       ret_i = 0, retw_i = 0, reti_i = 0, pcl_wr_i = 0, int_i = 0;
  logic [9:0] target_i = '0;
  logic [7:0] alu_i = '0;
  logic [1:0] hi_latch_i = '0;
  logic [9:0] fetch_addr_o;
  logic [7:0] pcl_o;
  logic       flush_o;

  int checks = 0, failures = 0;
  logic [9:0] m_pc;
  logic [9:0] m_ring [8];
  logic [2:0] m_idx;
  logic       m_flush;
  string      m_tag;

  always #5 clk_i = ~clk_i;

  prog_counter dut_i (.*);

  function automatic string tag_of(logic i, logic c, logic j, logic r, logic p,
                                   logic s, logic a);
    if (i) return "R8/R9";
    if (c) return "R5/R10";
    if (j) return "R4";
    if (r) return "R6/R10";
    if (p) return "R7";
    if (s) return "R3";
    if (a) return "R2";
    return "R9";
  endfunction

  // model update per requirements R2..R11
  task automatic predict();
    logic ra;
    ra = ret_i | retw_i | reti_i;
    m_tag   = tag_of(int_i, call_i, jump_i, ra, pcl_wr_i, skip_i, adv_i);
    m_flush = int_i | call_i | jump_i | ra | pcl_wr_i;
    if (int_i) begin
      m_ring[m_idx] = m_pc; m_idx = m_idx + 3'd1; m_pc = 10'h004;
    end else if (call_i) begin
      m_ring[m_idx] = m_pc + 10'd1; m_idx = m_idx + 3'd1; m_pc = target_i;
    end else if (jump_i) m_pc = target_i;
    else if (ra) begin
      m_idx = m_idx - 3'd1; m_pc = m_ring[m_idx];
    end else if (pcl_wr_i) m_pc = {hi_latch_i, alu_i};
    else if (skip_i) m_pc = m_pc + 10'd2;
    else if (adv_i)  m_pc = m_pc + 10'd1;
  endtask

  task automatic compare(string tag);
    checks++;
    if (fetch_addr_o !== m_pc || pcl_o !== m_pc[7:0] || flush_o !== m_flush) begin
      failures++;
      $display("FAIL %s: addr=%h pcl=%h flush=%b expected addr=%h pcl=%h flush=%b",
               tag, fetch_addr_o, pcl_o, flush_o, m_pc, m_pc[7:0], m_flush);
    end
  endtask

  task automatic clear_in();
    {adv_i, skip_i, jump_i, call_i, ret_i, retw_i, reti_i, pcl_wr_i, int_i} = '0;
  endtask

  // drive at negedge, predict, then check one negedge later
  task automatic step();
    predict();
    @(negedge clk_i);
    compare(m_tag);
    clear_in();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    m_pc = '0; m_idx = '0; m_flush = 1'b0; m_tag = "R1";
    for (int k = 0; k < 8; k++) m_ring[k] = '0;
    repeat (3) @(negedge clk_i);
    compare("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1 after release");

    // R2 wrap from 3FF: jump to 3FE then advance twice
    jump_i = 1; target_i = 10'h3FE; step();
    adv_i = 1; step();
    adv_i = 1; step();
    // R3 skip wrap from 3FF
    jump_i = 1; target_i = 10'h3FF; step();
    skip_i = 1; adv_i = 1; step();
    // R7 low-byte write
    pcl_wr_i = 1; alu_i = 8'hA5; hi_latch_i = 2'b10; step();
    // R10: nine nested calls then nine returns
    for (int k = 0; k < 9; k++) begin
      call_i = 1; target_i = 10'(16 * k + 3); step();
    end
    for (int k = 0; k < 9; k++) begin
      case (k % 3) 0: ret_i = 1; 1: retw_i = 1; default: reti_i = 1; endcase
      step();
    end
    // R8/R9 collision: interrupt with call and return
    jump_i = 1; target_i = 10'h155; step();
    int_i = 1; call_i = 1; ret_i = 1; target_i = 10'h2AA; step();
    reti_i = 1; step();
    // R9 hold
    step();
    step();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int unsigned r;
      r = $urandom_range(0, 99);
      adv_i    = ($urandom_range(0, 3) != 0);
      skip_i   = (r < 20);
      jump_i   = ($urandom_range(0, 15) == 0);
      call_i   = ($urandom_range(0, 9) == 0);
      ret_i    = ($urandom_range(0, 19) == 0);
      retw_i   = ($urandom_range(0, 29) == 0);
      reti_i   = ($urandom_range(0, 29) == 0);
      pcl_wr_i = ($urandom_range(0, 15) == 0);
      int_i    = ($urandom_range(0, 39) == 0);
      target_i   = 10'($urandom);
      alu_i      = 8'($urandom);
      hi_latch_i = 2'($urandom);
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule